// File: doc/BRIEF.md
# Multichannel ADC Serial Frame Transmitter

This block is the serial output stage of a six-channel simultaneous-sampling converter. It runs on the serial clock. A rising edge on the convert input starts a frame. On that edge the block captures the sample words of all channels and the requested channel count. It then sends the selected words one after another on a single data line, with an output enable that stands for the line's high-impedance state.

Each word takes a 16-clock slot. Fourteen of those clocks carry data, most significant bit first, and two leave the line released. The first bit appears after a fixed lead of three clocks. A convert edge that arrives while a frame is still running has no effect. A new frame is accepted on the exact clock where the current one ends, so frames can be chained into a continuous stream with no extra gap. The receiving side samples the data on the opposite clock edge.

Top module: `adc_frame_tx`

## Requirements
- R1: A convert rising edge is detected at the first serial-clock rising edge that sees `conv` high after a sample of it low. When accepted, that edge captures all of `samples` and `chan_sel`. Later changes on those inputs do not alter the frame.
- R2: After an accepted start at edge S, any convert rising edge detected at edges S+1 through S+L-1 is ignored, where L is 16 times the captured word count. It restarts nothing and changes neither the data sent nor the word count.
- R3: After an accepted start at edge S, the enable is low following edges S+1 and S+2 and high following edge S+3, carrying the first bit.
- R4: Words are sent in ascending channel order, starting with channel 0 taken from `samples[13:0]`; channel k is `samples[14k+13:14k]`. Each word is sent as 14 bits, most significant first. Following edge S+3+16w+j, `sdo` carries bit 13-j of word w, for j from 0 to 13.
- R5: After the 14 bits of every word, including the last, `sdo_oe` is low for exactly two clocks.
- R6: After reset, `sdo_oe` stays low until the third edge after the first accepted start.
- R7: `chan_sel` values 1 to 6 send that many words. A value of 0 is treated as 1, and 7 is treated as 6.
- R8: A convert rising edge detected at edge S+L is accepted. The new frame's first bit then follows the previous frame's two released clocks with no further gap.
- R9: The captured word count holds for the whole frame, whatever `chan_sel` does afterwards.
- R10: `rst_n` low forces `sdo_oe` low at once, without waiting for a clock edge. Release takes effect only after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state advances on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| conv | input | 1 | Convert request; a rising edge starts a frame |
| chan_sel | input | 3 | Number of words to send (0 means 1, 7 means 6) |
| samples | input | 84 | Six 14-bit sample words, channel 0 in the low bits |
| sdo | output | 1 | Serial data, meaningful only while `sdo_oe` is high |
| sdo_oe | output | 1 | Data line driven when high, released (high impedance) when low |

## Verification
The bench chains frames so that the second convert edge lands exactly on the clock where the first frame ends. A design that is off by one in its lockout either drops that edge or lets one clock early through, and either way the continuous bit stream shifts. Convert edges placed early in a frame and on its last locked clock, each with fresh samples and a different count, catch a design that restarts or recaptures mid-frame. Counts of 0 and 7 show whether the count is clamped or taken raw. A reset asserted in mid-word checks that the line is released before any clock edge, and that nothing resumes afterwards.

// File: rtl/afx_pkg.sv
`timescale 1ns/1ps
package afx_pkg;
  localparam int unsigned AFX_CH_MAX = 6;
  localparam int unsigned AFX_WBITS  = 14;
  localparam int unsigned AFX_SLOT   = 16;
  localparam int unsigned AFX_LEAD   = 3;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_DATA = 2'd1,
    ENG_GAP  = 2'd2
  } eng_state_e;
endpackage

// File: rtl/afx_rst_sync.sv
`timescale 1ns/1ps
module afx_rst_sync (
  input  logic sclk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/afx_frame_ctl.sv
`timescale 1ns/1ps
module afx_frame_ctl #(
  parameter  int unsigned CH_MAX = 6,
  parameter  int unsigned WBITS  = 14,
  parameter  int unsigned SLOT   = 16,
  localparam int unsigned SELW   = $clog2(CH_MAX + 1),
  localparam int unsigned FW     = $clog2(SLOT * CH_MAX),
  localparam int unsigned BANKW  = CH_MAX * WBITS
) (
  input  logic             sclk,
  input  logic             rst_sync_n,
  input  logic             conv,
  input  logic [SELW-1:0]  chan_sel,
  input  logic [BANKW-1:0] samples,
  output logic             start,
  output logic             busy,
  output logic [SELW-1:0]  n_lat,
  output logic [BANKW-1:0] bank
);
  logic             conv_q;
  logic [FW-1:0]    fcnt_q, fcnt_d;
  logic             busy_q, busy_d;
  logic [SELW-1:0]  n_q, n_d, n_eff;
  logic [BANKW-1:0] bank_q;
  logic [FW-1:0]    last_c;
  logic             rise;

  // Clamp the requested count into 1..CH_MAX
  always_comb begin
    if (chan_sel == '0)                 n_eff = SELW'(1);
    else if (chan_sel > SELW'(CH_MAX))  n_eff = SELW'(CH_MAX);
    else                                n_eff = chan_sel;
  end

  assign last_c = FW'(SLOT * n_q - 1);
  assign rise   = conv & ~conv_q;
  assign start  = rise & (~busy_q | (fcnt_q == last_c));

  always_comb begin
    busy_d = busy_q;
    fcnt_d = fcnt_q;
    n_d    = n_q;
    if (start) begin
      busy_d = 1'b1;
      fcnt_d = '0;
      n_d    = n_eff;
    end else if (busy_q) begin
      if (fcnt_q == last_c) busy_d = 1'b0;
      else                  fcnt_d = fcnt_q + FW'(1);
    end
  end

  always_ff @(posedge sclk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      conv_q <= 1'b0;
      busy_q <= 1'b0;
      fcnt_q <= '0;
      n_q    <= SELW'(1);
    end else begin
      conv_q <= conv;
      busy_q <= busy_d;
      fcnt_q <= fcnt_d;
      n_q    <= n_d;
    end
  end

  // Sample bank: clock enable is the accepted start
  always_ff @(posedge sclk or negedge rst_sync_n) begin
    if (!rst_sync_n)  bank_q <= '0;
    else if (start)   bank_q <= samples;
  end

  assign busy  = busy_q;
  assign n_lat = n_q;
  assign bank  = bank_q;
endmodule

// File: rtl/afx_shifter.sv
`timescale 1ns/1ps
module afx_shifter
  import afx_pkg::*;
#(
  parameter  int unsigned CH_MAX = 6,
  parameter  int unsigned WBITS  = 14,
  parameter  int unsigned SLOT   = 16,
  parameter  int unsigned LEAD   = 3,
  localparam int unsigned SELW   = $clog2(CH_MAX + 1),
  localparam int unsigned PW     = $clog2(SLOT),
  localparam int unsigned DW     = (LEAD > 1) ? $clog2(LEAD) : 1,
  localparam int unsigned BANKW  = CH_MAX * WBITS
) (
  input  logic             sclk,
  input  logic             rst_sync_n,
  input  logic             start,
  input  logic [SELW-1:0]  n_lat,
  input  logic [BANKW-1:0] bank,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             run
);
  logic [WBITS-1:0] words [CH_MAX];

  for (genvar g = 0; g < CH_MAX; g++) begin : g_word
    assign words[g] = bank[g*WBITS +: WBITS];
  end

  eng_state_e       st_q, st_d;
  logic             pend_q, pend_d;
  logic [DW-1:0]    dly_q, dly_d;
  logic [PW-1:0]    ph_q, ph_d;
  logic [SELW-1:0]  widx_q, widx_d, wcnt_q, wcnt_d, nxt_idx;
  logic [WBITS-1:0] sreg_q, sreg_d, nxt_word;
  logic             oe_q, oe_d;
  logic             launch;

  assign launch  = pend_q & (dly_q == '0);
  assign nxt_idx = widx_q + SELW'(1);

  always_comb begin
    nxt_word = '0;
    for (int i = 0; i < CH_MAX; i++)
      if (nxt_idx == SELW'(i)) nxt_word = words[i];
  end

  // Lead-in countdown
  always_comb begin
    pend_d = pend_q;
    dly_d  = dly_q;
    if (start) begin
      pend_d = 1'b1;
      dly_d  = DW'(LEAD - 1);
    end else if (launch) begin
      pend_d = 1'b0;
    end else if (pend_q) begin
      dly_d  = dly_q - DW'(1);
    end
  end

  // Slot engine
  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    widx_d = widx_q;
    wcnt_d = wcnt_q;
    sreg_d = sreg_q;
    oe_d   = oe_q;
    if (launch) begin
      st_d   = ENG_DATA;
      ph_d   = '0;
      widx_d = '0;
      wcnt_d = n_lat;
      sreg_d = words[0];
      oe_d   = 1'b1;
    end else begin
      unique case (st_q)
        ENG_DATA: begin
          ph_d = ph_q + PW'(1);
          if (ph_q == PW'(WBITS - 1)) begin
            st_d = ENG_GAP;
            oe_d = 1'b0;
          end else begin
            sreg_d = {sreg_q[WBITS-2:0], 1'b0};
          end
        end
        ENG_GAP: begin
          ph_d = ph_q + PW'(1);
          if (ph_q == PW'(SLOT - 1)) begin
            ph_d = '0;
            if (nxt_idx < wcnt_q) begin
              st_d   = ENG_DATA;
              widx_d = nxt_idx;
              sreg_d = nxt_word;
              oe_d   = 1'b1;
            end else begin
              st_d = ENG_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge sclk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ENG_IDLE;
      pend_q <= 1'b0;
      dly_q  <= '0;
      ph_q   <= '0;
      widx_q <= '0;
      wcnt_q <= '0;
      sreg_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      dly_q  <= dly_d;
      ph_q   <= ph_d;
      widx_q <= widx_d;
      wcnt_q <= wcnt_d;
      sreg_q <= sreg_d;
      oe_q   <= oe_d;
    end
  end

  assign sdo    = sreg_q[WBITS-1];
  assign sdo_oe = oe_q;
  assign run    = pend_q | (st_q != ENG_IDLE);
endmodule

// File: rtl/adc_frame_tx.sv
`timescale 1ns/1ps
module adc_frame_tx
  import afx_pkg::*;
#(
  parameter  int unsigned CH_MAX = AFX_CH_MAX,
  parameter  int unsigned WBITS  = AFX_WBITS,
  parameter  int unsigned SLOT   = AFX_SLOT,
  parameter  int unsigned LEAD   = AFX_LEAD,
  localparam int unsigned SELW   = $clog2(CH_MAX + 1),
  localparam int unsigned BANKW  = CH_MAX * WBITS
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             conv,
  input  logic [SELW-1:0]  chan_sel,
  input  logic [BANKW-1:0] samples,
  output logic             sdo,
  output logic             sdo_oe
);
  logic             rst_sync_n;
  logic             start;
  logic             busy;
  logic             eng_run;
  logic [SELW-1:0]  n_lat;
  logic [BANKW-1:0] bank;

  afx_rst_sync u_rst (
    .sclk       (sclk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  afx_frame_ctl #(.CH_MAX(CH_MAX), .WBITS(WBITS), .SLOT(SLOT)) u_ctl (
    .sclk       (sclk),
    .rst_sync_n (rst_sync_n),
    .conv       (conv),
    .chan_sel   (chan_sel),
    .samples    (samples),
    .start      (start),
    .busy       (busy),
    .n_lat      (n_lat),
    .bank       (bank)
  );

  afx_shifter #(.CH_MAX(CH_MAX), .WBITS(WBITS), .SLOT(SLOT), .LEAD(LEAD)) u_shf (
    .sclk       (sclk),
    .rst_sync_n (rst_sync_n),
    .start      (start),
    .n_lat      (n_lat),
    .bank       (bank),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .run        (eng_run)
  );
endmodule

// File: rtl/afx_checker.sv
`timescale 1ns/1ps
module afx_checker #(
  parameter int unsigned SELW = 3
) (
  input logic            sclk,
  input logic            rst_sync_n,
  input logic            start,
  input logic            busy,
  input logic            eng_run,
  input logic [SELW-1:0] n_lat,
  input logic            sdo_oe
);
  // R2: a frame lasts at least one slot, so two starts never touch
  a_r2_no_restart: assert property (@(posedge sclk) disable iff (!rst_sync_n)
    start |=> !start);

  // R3: two released clocks, then the first bit
  a_r3_lead: assert property (@(posedge sclk) disable iff (!rst_sync_n)
    start |-> ##2 !sdo_oe ##1 !sdo_oe ##1 sdo_oe);

  // R4: a word is never a single bit long
  a_r4_word_run: assert property (@(posedge sclk) disable iff (!rst_sync_n)
    $rose(sdo_oe) |=> sdo_oe);

  // R5: every release lasts at least two clocks
  a_r5_gap: assert property (@(posedge sclk) disable iff (!rst_sync_n)
    $fell(sdo_oe) |=> !sdo_oe);

  // R6: line released whenever neither frame control nor engine is active
  a_r6_quiet: assert property (@(posedge sclk) disable iff (!rst_sync_n)
    (!busy && !eng_run) |-> !sdo_oe);

  // R9: captured count stays put while a frame runs
  a_r9_count_held: assert property (@(posedge sclk) disable iff (!rst_sync_n)
    (busy && !start) |=> $stable(n_lat));
endmodule

bind adc_frame_tx afx_checker #(.SELW(SELW)) u_chk (
  .sclk       (sclk),
  .rst_sync_n (rst_sync_n),
  .start      (start),
  .busy       (busy),
  .eng_run    (eng_run),
  .n_lat      (n_lat),
  .sdo_oe     (sdo_oe)
);

// File: tb/tb_adc_frame_tx.sv
`timescale 1ns/1ps
module tb_adc_frame_tx;
  localparam int CH = 6;
  localparam int WB = 14;

  logic             sclk = 1'b0;
  logic             rst_n;
  logic             conv;
  logic [2:0]       chan_sel;
  logic [CH*WB-1:0] samples;
  logic             sdo;
  logic             sdo_oe;

  always #10 sclk = ~sclk;

  adc_frame_tx dut (
    .sclk(sclk), .rst_n(rst_n), .conv(conv), .chan_sel(chan_sel),
    .samples(samples), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  int  cyc = 0;
  int  n_chk = 0;
  int  n_bad = 0;
  int  oe_seen = 0;
  bit  mon_en = 1'b0;
  bit  done = 1'b0;

  bit          cur_v, prev_v;
  int          cur_s, prev_s, cur_n, prev_n;
  logic [13:0] cur_w [CH];
  logic [13:0] prev_w [CH];

  always @(posedge sclk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int eff(input int s);
    return (s == 0) ? 1 : ((s > CH) ? CH : s);
  endfunction

  // Bench model of the stream, derived from R3/R4/R5/R6/R7
  always @(negedge sclk) begin
    if (mon_en) begin
      bit          eo, ed, have;
      int          k, n, slot, b;
      string       tag;
      logic [13:0] w;
      have = 1'b0; eo = 1'b0; ed = 1'b0; k = 0; n = 0; w = '0;
      if (cur_v && (cur_s + 3 <= cyc)) begin
        have = 1'b1; k = cyc - cur_s; n = cur_n;
      end else if (prev_v) begin
        have = 1'b1; k = cyc - prev_s; n = prev_n;
      end
      slot = (k - 3) / 16;
      b    = (k - 3) % 16;
      if (have && k >= 3 && slot < n && b < 14) begin
        eo = 1'b1;
        w  = (cur_v && (cur_s + 3 <= cyc)) ? cur_w[slot] : prev_w[slot];
        ed = w[13 - b];
      end
      if (!have)                        tag = "R6";
      else if (k < 3)                   tag = "R3";
      else if (slot >= n)               tag = "R7";
      else if (b >= 14)                 tag = "R5";
      else                              tag = "R4";
      check(sdo_oe == eo, {tag, " enable"}, int'(sdo_oe), int'(eo));
      if (eo) check(sdo == ed, "R4 data bit", int'(sdo), int'(ed));
      if (sdo_oe) oe_seen++;
    end
  end

  // Called at a negedge: raises conv so edge cyc+1 sees the rise (R1)
  task automatic pulse(input int sel, input logic [CH*WB-1:0] smp, output int s_edge);
    int c;
    chan_sel = 3'(sel);
    samples  = smp;
    conv     = 1'b1;
    c        = cyc + 1;
    s_edge   = c;
    if (!cur_v || (c - cur_s) >= 16 * cur_n) begin
      prev_v = cur_v; prev_s = cur_s; prev_n = cur_n;
      for (int i = 0; i < CH; i++) prev_w[i] = cur_w[i];
      cur_v = 1'b1; cur_s = c; cur_n = eff(sel);
      for (int i = 0; i < CH; i++) cur_w[i] = smp[i*WB +: WB];
    end
    @(negedge sclk);
    conv = 1'b0;
  endtask

  task automatic wait_to(input int e);
    while (cyc < e - 1) @(negedge sclk);
  endtask

  task automatic do_reset();
    mon_en = 1'b0;
    rst_n = 1'b0; conv = 1'b0; chan_sel = 3'd6; samples = '0;
    cur_v = 1'b0; prev_v = 1'b0; cur_s = 0; prev_s = 0; cur_n = 1; prev_n = 1;
    repeat (3) @(negedge sclk);
    rst_n = 1'b1;
    repeat (3) @(negedge sclk);
    mon_en = 1'b1;
  endtask

  function automatic logic [CH*WB-1:0] pat(input int seed);
    logic [CH*WB-1:0] v;
    for (int i = 0; i < CH; i++) v[i*WB +: WB] = 14'((seed * 4099 + i * 2731) ^ (i << 9));
    return v;
  endfunction

  task automatic t_reset();
    do_reset();
    check(sdo_oe == 1'b0, "R6 after reset", int'(sdo_oe), 0);
    oe_seen = 0;
    repeat (20) @(negedge sclk);
    check(oe_seen == 0, "R6 idle window", oe_seen, 0);
  endtask

  task automatic t_full();
    int s;
    oe_seen = 0;
    pulse(6, pat(1), s);
    samples = ~pat(1);   // R1: changes after capture must not show
    chan_sel = 3'd1;
    wait_to(s + 100);
    check(oe_seen == 84, "R7 six words", oe_seen, 84);
  endtask

  task automatic t_counts();
    int s;
    int sels [4] = '{1, 3, 0, 7};
    foreach (sels[i]) begin
      oe_seen = 0;
      pulse(sels[i], pat(10 + i), s);
      wait_to(s + 16 * eff(sels[i]) + 6);
      check(oe_seen == 14 * eff(sels[i]), "R7 word count", oe_seen, 14 * eff(sels[i]));
    end
  endtask

  task automatic t_lock();
    int s, x;
    oe_seen = 0;
    pulse(6, pat(20), s);
    wait_to(s + 10);
    pulse(1, pat(21), x);   // R2 and R9: ignored mid-frame
    wait_to(s + 95);
    pulse(2, pat(22), x);   // R2: last locked edge
    wait_to(s + 110);
    check(oe_seen == 84, "R2 lockout kept frame", oe_seen, 84);
  endtask

  task automatic t_b2b();
    int s, s2, x;
    oe_seen = 0;
    pulse(2, pat(30), s);
    wait_to(s + 32);
    pulse(3, pat(31), s2);  // R8: accepted on the closing edge
    check(s2 == s + 32, "R8 start edge", s2 - s, 32);
    wait_to(s2 + 47);
    pulse(1, pat(32), x);   // R2: one edge too early for the 3-word frame
    wait_to(s2 + 60);
    check(oe_seen == 70, "R8 chained words", oe_seen, 70);
  endtask

  task automatic t_async();
    int s;
    pulse(6, pat(40), s);
    wait_to(s + 21);
    check(sdo_oe == 1'b1, "R4 mid-word enable", int'(sdo_oe), 1);
    mon_en = 1'b0;
    rst_n = 1'b0;
    #2;
    check(sdo_oe == 1'b0, "R10 async clear", int'(sdo_oe), 0);
    do_reset();
    oe_seen = 0;
    repeat (30) @(negedge sclk);
    check(oe_seen == 0, "R10 no resume", oe_seen, 0);
  endtask

  initial begin
    t_reset();
    t_full();
    t_counts();
    t_lock();
    t_b2b();
    t_async();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge sclk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule